// File: doc/BRIEF.md
# Store Queue with Deferred Writeback

This block buffers stores between execution and retirement and sends them to the data cache strictly in program order after they commit. Stores are allocated at a tail pointer in program order. They receive their address, data and byte size when they execute. A commit request then marks every store up to a given sequence number as eligible to write. A separate writeback pointer walks the eligible stores one per cycle and sends each one to the cache over a valid/ready channel. A head pointer frees storage once stores complete. Completions may arrive out of order, but storage is always reclaimed from the head.

A refused write is held inside the block and resent only when the retry input pulses. Entries with zero size need no cache access, and neither do store-conditionals whose success input is low. Both finish at once. A squash request removes speculative stores from the tail, but it never removes a store that has already been marked to write. A single load can be recorded as waiting on one store. When that store is sent or completes, the block asks for the load to be replayed.

Top module: `sq_deferred_wb`

## Requirements
- R1: The queue holds up to DEPTH stores in DEPTH+1 slots. `alloc_idx` is the slot the next allocation takes, counting 0,1,…,DEPTH and then wrapping to 0. `full` is high when `used` equals DEPTH, and an allocation while full (or in a squash cycle) is ignored. After reset `used`, `elig`, `blocked`, `blk_cnt`, `wr_valid`, `full` and `alloc_idx` are all zero.
- R2: A commit with number C walks from the oldest store and marks each store with sequence number ≤ C. It stops at the first unmarked store with a larger number. `elig` (marked, not yet completed stores) rises by the number marked, visible the next cycle.
- R3: An executed store-conditional marks itself without a commit and adds one to `elig`.
- R4: Marked stores are sent in allocation order, at most one per cycle, from the writeback pointer. `wr_idx`/`wr_addr`/`wr_data`/`wr_size` carry the entry's slot and executed fields. The pointer advances on `wr_valid && wr_ready`.
- R5: A marked entry with size 0 completes in one cycle without raising `wr_valid`.
- R6: A marked store-conditional reaching the writeback pointer while `sc_pass` is low completes without raising `wr_valid`. `sc_fail_valid` pulses on the next cycle with its slot in `sc_fail_idx`.
- R7: A refused write sets `blocked` and adds one to `blk_cnt`. While blocked, `wr_valid` stays low except in cycles where `wr_retry` is high, when the same request is presented again. A second refusal adds one more to `blk_cnt` and keeps `blocked`. Acceptance clears `blocked` and advances the pointer.
- R8: `cpl_valid` with a sent slot completes it and lowers `elig` by one. Storage is freed only from the head, over every consecutive completed entry, so an out-of-order completion leaves `used` unchanged until the older stores complete.
- R9: A squash with number S frees stores from the tail backwards while their number exceeds S, and stops at the first marked store. A commit in the same cycle is applied before the squash.
- R10: After `stall_set` records a store slot and a load index, the send or completion of that store raises `replay_valid` for one cycle on the next edge, with the recorded index in `replay_load_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_sc | input | 1 | New store is a store-conditional |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| full | output | 1 | Queue holds DEPTH stores |
| exec_valid | input | 1 | A store has executed |
| exec_idx | input | IDX_W | Slot of the executed store |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| exec_size | input | SIZE_W | Store size in bytes, 0 means no access |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| sc_pass | input | 1 | Outcome of the store-conditional at the writeback pointer |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_size | output | SIZE_W | Write size |
| wr_idx | output | IDX_W | Slot of the written store |
| wr_retry | input | 1 | Cache can take the held request |
| cpl_valid | input | 1 | A sent store has completed |
| cpl_idx | input | IDX_W | Slot of the completed store |
| stall_set | input | 1 | Record a load waiting on a store |
| stall_store_idx | input | IDX_W | Store slot the load waits on |
| stall_load_idx | input | LQ_W | Index of the waiting load |
| replay_valid | output | 1 | Replay request for the waiting load |
| replay_load_idx | output | LQ_W | Load to replay |
| sc_fail_valid | output | 1 | A store-conditional failed and completed |
| sc_fail_idx | output | IDX_W | Slot of the failed store-conditional |
| blocked | output | 1 | A refused write is held |
| blk_cnt | output | BLK_W | Saturating count of refusals |
| used | output | CNT_W | Stores held |
| elig | output | CNT_W | Marked stores not yet completed |

## Verification
The hardest state to reach from the ports is a held request that is refused a second time on retry while the slot behind it is a zero-size store and the one after it is still unmarked. The stimulus fills the queue across the wrap point and lowers `wr_ready` before the commit. It then pulses `wr_retry` once with the cache still refusing and once with it accepting. After that it combines a commit and a squash in one cycle, so that the squash lands against a store just marked. Out-of-order completion is also driven so that freeing storage has to jump over a run of completed slots.

// File: rtl/sq_wb_pkg.sv
package sq_wb_pkg;
   // Action taken at the writeback pointer in one cycle
   typedef enum logic [2:0] {
      WB_NONE,
      WB_SKIP,     // zero-size entry, completes locally
      WB_SCFAIL,   // failed store-conditional, completes locally
      WB_SEND,     // request accepted by the cache
      WB_REFUSED   // request presented and refused
   } wb_act_e;
endpackage

// File: rtl/sq_sat_counter.sv
module sq_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)                  count <= '0;
      else if (inc && count != '1) count <= count + 1'b1;
   end

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '1) |=> (count == '1)); // R7
endmodule

// File: rtl/sq_stall_track.sv
module sq_stall_track #(
   parameter int IDX_W = 3,
   parameter int LQ_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_v,
   input  logic [IDX_W-1:0] set_store,
   input  logic [LQ_W-1:0]  set_load,
   input  logic             ev_a_v,
   input  logic [IDX_W-1:0] ev_a_idx,
   input  logic             ev_b_v,
   input  logic [IDX_W-1:0] ev_b_idx,
   output logic             replay_valid,
   output logic [LQ_W-1:0]  replay_load
);
   logic             stall_act;
   logic [IDX_W-1:0] stall_st;
   logic [LQ_W-1:0]  stall_ld;
   logic             hit;

   assign hit = stall_act && ((ev_a_v && ev_a_idx == stall_st) ||
                              (ev_b_v && ev_b_idx == stall_st));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_act    <= 1'b0;
         stall_st     <= '0;
         stall_ld     <= '0;
         replay_valid <= 1'b0;
         replay_load  <= '0;
      end else begin
         replay_valid <= hit;
         if (hit) begin
            replay_load <= stall_ld;
            stall_act   <= 1'b0;
         end
         if (set_v) begin
            stall_act <= 1'b1;
            stall_st  <= set_store;
            stall_ld  <= set_load;
         end
      end
   end

   AST_REPLAY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> $past(stall_act)); // R10
endmodule

// File: rtl/sq_deferred_wb.sv
module sq_deferred_wb
   import sq_wb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int SEQ_W  = 16,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 4,
   parameter int LQ_W   = 4,
   parameter int BLK_W  = 8,
   localparam int SLOTS = DEPTH + 1,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic              alloc_sc,
   output logic [IDX_W-1:0]  alloc_idx,
   output logic              full,
   input  logic              exec_valid,
   input  logic [IDX_W-1:0]  exec_idx,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic [DATA_W-1:0] exec_data,
   input  logic [SIZE_W-1:0] exec_size,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              sc_pass,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [SIZE_W-1:0] wr_size,
   output logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_retry,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_idx,
   input  logic              stall_set,
   input  logic [IDX_W-1:0]  stall_store_idx,
   input  logic [LQ_W-1:0]   stall_load_idx,
   output logic              replay_valid,
   output logic [LQ_W-1:0]   replay_load_idx,
   output logic              sc_fail_valid,
   output logic [IDX_W-1:0]  sc_fail_idx,
   output logic              blocked,
   output logic [BLK_W-1:0]  blk_cnt,
   output logic [CNT_W-1:0]  used,
   output logic [CNT_W-1:0]  elig
);
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      initial $fatal(1, "sq_deferred_wb: DEPTH must be within 2..64");
   end
   if (SIZE_W < 1 || SEQ_W < 2) begin : g_bad_width
      initial $fatal(1, "sq_deferred_wb: SIZE_W and SEQ_W too small");
   end

   typedef struct packed {
      logic              vld;
      logic              sc;
      logic              canwb;
      logic              sent;
      logic              done;
      logic [SEQ_W-1:0]  seq;
      logic [SIZE_W-1:0] size;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } ent_t;

   ent_t             q   [SLOTS];
   ent_t             n_q [SLOTS];
   logic [IDX_W-1:0] head, tail, wbp, n_head, n_tail, n_wbp;
   logic [CNT_W-1:0] n_used, n_elig;
   logic             n_blk, cpl_ok, sc_fail_q;
   logic [IDX_W-1:0] sc_fail_idx_q;
   wb_act_e          act;

   function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
      return (p == IDX_W'(SLOTS - 1)) ? '0 : p + 1'b1;
   endfunction
   function automatic logic [IDX_W-1:0] prv(input logic [IDX_W-1:0] p);
      return (p == '0) ? IDX_W'(SLOTS - 1) : p - 1'b1;
   endfunction

   assign alloc_idx = tail;
   assign full      = (used == CNT_W'(DEPTH));
   assign cpl_ok    = cpl_valid && q[cpl_idx].vld && q[cpl_idx].sent && !q[cpl_idx].done;

   // Decision at the writeback pointer
   always_comb begin
      act = WB_NONE;
      if (blocked) begin
         if (wr_retry) act = wr_ready ? WB_SEND : WB_REFUSED;
      end else if (elig != '0 && wbp != tail && q[wbp].vld && q[wbp].canwb &&
                   !q[wbp].sent && !q[wbp].done) begin
         if (q[wbp].size == '0)           act = WB_SKIP;
         else if (q[wbp].sc && !sc_pass) act = WB_SCFAIL;
         else                             act = wr_ready ? WB_SEND : WB_REFUSED;
      end
   end

   assign wr_valid = (act == WB_SEND) || (act == WB_REFUSED);
   assign wr_addr  = q[wbp].addr;
   assign wr_data  = q[wbp].data;
   assign wr_size  = q[wbp].size;
   assign wr_idx   = wbp;

   // Next-state of the queue
   always_comb begin
      logic [IDX_W-1:0] p, t, h;
      logic             stop;
      int               e_inc, e_dec;
      n_q   = q;
      n_blk = blocked;
      n_wbp = wbp;
      e_inc = 0;
      e_dec = 0;
      case (act)
         WB_SKIP, WB_SCFAIL: begin
            n_q[wbp].done = 1'b1;
            e_dec         = e_dec + 1;
            n_wbp         = nxt(wbp);
         end
         WB_SEND: begin
            n_q[wbp].sent = 1'b1;
            n_wbp         = nxt(wbp);
            n_blk         = 1'b0;
         end
         WB_REFUSED: n_blk = 1'b1;
         default: ;
      endcase
      if (cpl_ok) begin
         n_q[cpl_idx].done = 1'b1;
         e_dec             = e_dec + 1;
      end
      // Commit walk, oldest first
      p    = head;
      stop = 1'b0;
      if (commit_valid) begin
         for (int k = 0; k < SLOTS; k++) begin
            if (!stop && p != tail) begin
               if (!n_q[p].canwb) begin
                  if (n_q[p].seq > commit_seq) stop = 1'b1;
                  else begin
                     n_q[p].canwb = 1'b1;
                     e_inc        = e_inc + 1;
                  end
               end
               p = nxt(p);
            end
         end
      end
      if (exec_valid && q[exec_idx].vld) begin
         n_q[exec_idx].addr = exec_addr;
         n_q[exec_idx].data = exec_data;
         n_q[exec_idx].size = exec_size;
         if (q[exec_idx].sc && !n_q[exec_idx].canwb) begin
            n_q[exec_idx].canwb = 1'b1;
            e_inc               = e_inc + 1;
         end
      end
      // Squash walk, youngest first, halts at a marked store
      t    = tail;
      stop = 1'b0;
      if (squash_valid) begin
         for (int k = 0; k < SLOTS; k++) begin
            if (!stop && t != head) begin
               p = prv(t);
               if (n_q[p].seq > squash_seq && !n_q[p].canwb) begin
                  n_q[p] = '0;
                  t      = p;
               end else stop = 1'b1;
            end
         end
      end
      if (alloc_valid && !squash_valid && !full) begin
         n_q[t]     = '0;
         n_q[t].vld = 1'b1;
         n_q[t].sc  = alloc_sc;
         n_q[t].seq = alloc_seq;
         t          = nxt(t);
      end
      n_tail = t;
      // Reclaim completed run at the head
      h    = head;
      stop = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
         if (!stop && h != t && n_q[h].done) begin
            n_q[h] = '0;
            h      = nxt(h);
         end else stop = 1'b1;
      end
      n_head = h;
      n_used = CNT_W'((int'(t) - int'(h) + SLOTS) % SLOTS);
      n_elig = CNT_W'(int'(elig) + e_inc - e_dec);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) q[i] <= '0;
         head          <= '0;
         tail          <= '0;
         wbp           <= '0;
         used          <= '0;
         elig          <= '0;
         blocked       <= 1'b0;
         sc_fail_q     <= 1'b0;
         sc_fail_idx_q <= '0;
      end else begin
         q             <= n_q;
         head          <= n_head;
         tail          <= n_tail;
         wbp           <= n_wbp;
         used          <= n_used;
         elig          <= n_elig;
         blocked       <= n_blk;
         sc_fail_q     <= (act == WB_SCFAIL);
         sc_fail_idx_q <= wbp;
      end
   end

   assign sc_fail_valid = sc_fail_q;
   assign sc_fail_idx   = sc_fail_idx_q;

   sq_sat_counter #(.W(BLK_W)) u_blk_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (act == WB_REFUSED),
      .count (blk_cnt)
   );

   sq_stall_track #(.IDX_W(IDX_W), .LQ_W(LQ_W)) u_stall (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_v        (stall_set),
      .set_store    (stall_store_idx),
      .set_load     (stall_load_idx),
      .ev_a_v       (act == WB_SEND || act == WB_SKIP || act == WB_SCFAIL),
      .ev_a_idx     (wbp),
      .ev_b_v       (cpl_ok),
      .ev_b_idx     (cpl_idx),
      .replay_valid (replay_valid),
      .replay_load  (replay_load_idx)
   );

   AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CNT_W'(DEPTH)); // R1
   AST_ELIG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      elig <= used); // R2
   AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && !wr_retry) |-> !wr_valid); // R7
   AST_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blocked) |-> $past(wr_valid && !wr_ready)); // R7
   AST_SCFAIL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fail_valid |-> $past(!wr_valid)); // R6
endmodule

// File: tb/tb_sq_deferred_wb.sv
module tb_sq_deferred_wb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_valid = 0, alloc_sc = 0, exec_valid = 0, commit_valid = 0;
   logic        squash_valid = 0, sc_pass = 1, wr_ready = 1, wr_retry = 0;
   logic        cpl_valid = 0, stall_set = 0;
   logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
   logic [2:0]  exec_idx = 0, cpl_idx = 0, stall_store_idx = 0;
   logic [31:0] exec_addr = 0, exec_data = 0;
   logic [3:0]  exec_size = 0, stall_load_idx = 0;
   logic [2:0]  alloc_idx, wr_idx, sc_fail_idx, used, elig;
   logic        full, wr_valid, replay_valid, sc_fail_valid, blocked;
   logic [31:0] wr_addr, wr_data;
   logic [3:0]  wr_size, replay_load_idx;
   logic [7:0]  blk_cnt;
   int          checks = 0, errors = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   sq_deferred_wb dut (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
      .alloc_sc(alloc_sc), .alloc_idx(alloc_idx), .full(full), .exec_valid(exec_valid),
      .exec_idx(exec_idx), .exec_addr(exec_addr), .exec_data(exec_data),
      .exec_size(exec_size), .commit_valid(commit_valid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq), .sc_pass(sc_pass),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_size(wr_size), .wr_idx(wr_idx), .wr_retry(wr_retry), .cpl_valid(cpl_valid),
      .cpl_idx(cpl_idx), .stall_set(stall_set), .stall_store_idx(stall_store_idx),
      .stall_load_idx(stall_load_idx), .replay_valid(replay_valid),
      .replay_load_idx(replay_load_idx), .sc_fail_valid(sc_fail_valid),
      .sc_fail_idx(sc_fail_idx), .blocked(blocked), .blk_cnt(blk_cnt),
      .used(used), .elig(elig)
   );

   localparam int NV = 4;
   localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h204, 32'h308, 32'h40C};
   localparam logic [31:0] V_DATA [NV] = '{32'hCAFE0001, 32'h0BAD0002, 32'h12340003, 32'h55AA0004};

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic do_alloc(input logic [15:0] s, input logic sc);
      alloc_valid = 1; alloc_seq = s; alloc_sc = sc;
      tick();
      alloc_valid = 0; alloc_sc = 0;
   endtask

   task automatic do_exec(input logic [2:0] i, input logic [31:0] a, input logic [31:0] d, input logic [3:0] sz);
      exec_valid = 1; exec_idx = i; exec_addr = a; exec_data = d; exec_size = sz;
      tick();
      exec_valid = 0;
   endtask

   task automatic do_cpl(input logic [2:0] i);
      cpl_valid = 1; cpl_idx = i;
      tick();
      cpl_valid = 0;
   endtask

   task automatic do_commit(input logic [15:0] s);
      commit_valid = 1; commit_seq = s;
      tick();
      commit_valid = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R11-style reset state, tagged with R1
      chk("R1", "reset used", used, 0);
      chk("R1", "reset elig", elig, 0);
      chk("R1", "reset full", full, 0);
      chk("R1", "reset alloc_idx", alloc_idx, 0);
      chk("R7", "reset blocked", {blocked, blk_cnt}, 0);
      chk("R4", "reset wr_valid", wr_valid, 0);
      @(negedge clk); rst_n = 1; #1;

      // Table-driven in-order writeback
      for (int k = 0; k < NV; k++) begin
         chk("R1", "alloc_idx", alloc_idx, k);
         do_alloc(16'(k + 1), 0);
      end
      chk("R1", "full after fill", full, 1);
      for (int k = 0; k < NV; k++) do_exec(3'(k), V_ADDR[k], V_DATA[k], 4'd4);
      chk("R4", "no write before commit", wr_valid, 0);
      do_commit(16'd4);
      chk("R2", "elig after commit", elig, 4);
      for (int k = 0; k < NV; k++) begin
         chk("R4", "wr_valid", wr_valid, 1);
         chk("R4", "wr_idx", wr_idx, k);
         chk("R4", "wr_data", wr_data, V_DATA[k]);
         chk("R4", "wr_addr", wr_addr, V_ADDR[k]);
         tick();
      end
      chk("R4", "idle after last", wr_valid, 0);
      alloc_valid = 1; alloc_seq = 16'd99; tick(); alloc_valid = 0;
      chk("R1", "alloc while full ignored", used, 4);
      do_cpl(3'd2);
      chk("R8", "out-of-order completion keeps used", used, 4);
      chk("R8", "elig after one completion", elig, 3);
      do_cpl(3'd0);
      chk("R8", "head frees one", used, 3);
      do_cpl(3'd1);
      chk("R8", "head skips completed run", used, 1);
      do_cpl(3'd3);
      chk("R8", "all freed", used, 0);

      // Refusal, retry, zero size, commit+squash
      chk("R1", "alloc_idx at last slot", alloc_idx, 4);
      do_alloc(16'd10, 0);
      chk("R1", "alloc_idx wraps", alloc_idx, 0);
      do_alloc(16'd11, 0);
      do_alloc(16'd12, 0);
      do_alloc(16'd13, 0);
      do_exec(3'd4, 32'hA0, 32'h0000000A, 4'd4);
      do_exec(3'd0, 32'hB0, 32'h0000000B, 4'd0);
      do_exec(3'd1, 32'hC0, 32'h0000000C, 4'd4);
      do_exec(3'd2, 32'hD0, 32'h0000000D, 4'd4);
      wr_ready = 0;
      do_commit(16'd11);
      chk("R2", "commit stops at first younger", elig, 2);
      chk("R4", "first request slot", {wr_valid, wr_idx}, {1'b1, 3'd4});
      tick();
      chk("R7", "blocked after refusal", blocked, 1);
      chk("R7", "blk_cnt one", blk_cnt, 1);
      chk("R7", "held quiet", wr_valid, 0);
      wr_retry = 1; #0;
      chk("R7", "retry re-presents", {wr_valid, wr_idx}, {1'b1, 3'd4});
      tick();
      chk("R7", "second refusal", {blocked, blk_cnt}, {1'b1, 8'd2});
      wr_ready = 1;
      tick();
      wr_retry = 0; #0;
      chk("R7", "accepted clears blocked", blocked, 0);
      chk("R5", "zero size makes no request", wr_valid, 0);
      tick();
      chk("R5", "zero size completed", elig, 1);
      chk("R5", "zero size not at head", used, 4);
      commit_valid = 1; commit_seq = 16'd12; squash_valid = 1; squash_seq = 16'd5;
      tick();
      commit_valid = 0; squash_valid = 0;
      chk("R9", "squash stops at marked", used, 3);
      chk("R9", "marked store survives", elig, 2);
      chk("R4", "next request", {wr_valid, wr_idx, wr_data}, {1'b1, 3'd1, 32'h0000000C});
      tick();
      do_cpl(3'd4);
      chk("R8", "head over completed zero-size", used, 1);
      do_cpl(3'd1);
      chk("R8", "empty again", used, 0);

      // Failed store-conditional
      chk("R1", "alloc_idx after squash", alloc_idx, 2);
      do_alloc(16'd20, 1);
      sc_pass = 0;
      do_exec(3'd2, 32'hE0, 32'h0000000E, 4'd4);
      chk("R3", "sc marks itself", elig, 1);
      chk("R6", "failed sc no write", wr_valid, 0);
      tick();
      chk("R6", "sc fail pulse", {sc_fail_valid, sc_fail_idx}, {1'b1, 3'd2});
      chk("R6", "failed sc freed", used, 0);
      tick();
      chk("R6", "sc fail pulse ends", sc_fail_valid, 0);
      sc_pass = 1;

      // Stall and replay on a passing store-conditional
      do_alloc(16'd21, 1);
      stall_set = 1; stall_store_idx = 3'd3; stall_load_idx = 4'd7;
      tick();
      stall_set = 0;
      do_exec(3'd3, 32'hF0, 32'h0000000F, 4'd4);
      chk("R4", "passing sc writes", {wr_valid, wr_idx}, {1'b1, 3'd3});
      chk("R10", "no replay before send", replay_valid, 0);
      tick();
      chk("R10", "replay on send", {replay_valid, replay_load_idx}, {1'b1, 4'd7});
      do_cpl(3'd3);
      chk("R10", "replay one cycle", replay_valid, 0);
      chk("R8", "final empty", used, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule